// File: doc/BRIEF.md
# Frame Pulse Style Detector and Regenerator

This block sits at the timing input of a time-slot switch. It takes the 8 kHz master frame pulse and the 8.192 MHz bit clock. It samples both with a fast clock at sixteen times the bit rate. The fast clock comes from outside the block; no clock multiplier is included. The active edge of the bit clock can be chosen, so each bit period gives exactly one sample of the frame-pulse line.

The block works out on its own whether the frame pulse is active-low or active-high. It counts how often the line is high across each frame-length window of samples. A line that is high for most of the window carries an active-low pulse. Once two consecutive windows give the same answer, the convention is taken as settled. From then on, every pulse run is measured against the configured width of one or two bit periods:

- A run of the right width marks the frame boundary with a one-cycle strobe.
- A run of the wrong width sets a sticky error flag and is ignored.

Each accepted boundary realigns a free-running frame counter. That counter drives a regenerated frame pulse timed to an 8.192 MHz output clock, a second pulse timed to a 16.384 MHz output clock, and both clocks. The regenerated pulses use the width and polarity of the input pulse, and the clock level at the boundary can be selected.

Top module: `fpStyleGen`

## Requirements
- R1: The bit clock is sampled through SYNC_STAGES flops. Its falling edge is the active edge when cfgRiseEdge is 0, and its rising edge when cfgRiseEdge is 1. The frame-pulse line is sampled once per active edge, through the same synchroniser depth.
- R2: Over every window of C8_PER_FRAME samples, more than C8_PER_FRAME/2 high samples is a vote for active-low, and fewer is a vote for active-high. When two consecutive windows vote the same way, styleValid goes to 1 and stays there until reset. styleHigh shows the convention: 0 for active-low, 1 for active-high.
- R3: Once styleValid is 1, a run of active samples followed by an inactive sample marks bit 0 of channel 0. If the run is the correct width, frameStart is high for exactly one fast-clock cycle. It is registered on the third rising fast-clock edge that sees the new bit-clock level. frameStart is never high while styleValid is 0.
- R4: The expected run length is 2 when cfgDoubleWidth is 1 and 1 otherwise. A run of any other length (longer runs saturate at 3) sets widthErr. widthErr stays set until reset, and that pulse produces no frameStart.
- R5: The fast-clock cycle after frameStart is frame position 0. At that position c8Out and c16Out both equal cfgOutPol. c8Out toggles every OVS/2 fast cycles and c16Out every OVS/4.
- R6: fp8Out is active for the last W*OVS fast cycles of each frame and fp16Out for the last W*OVS/2, where W is 1 or 2 from cfgDoubleWidth. Both pulses end just before position 0.
- R7: The active level of fp8Out and fp16Out is styleHigh. Before styleValid both outputs are held high.
- R8: While rstN is low: frameStart, styleValid and widthErr are 0; fp8Out and fp16Out are 1; c8Out equals cfgOutPol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock, OVS times the bit rate |
| rstN | input | 1 | Asynchronous active-low reset |
| c8In | input | 1 | 8.192 MHz input bit clock |
| fpIn | input | 1 | 8 kHz master frame pulse |
| cfgDoubleWidth | input | 1 | 1: pulse spans two bit periods; 0: one |
| cfgRiseEdge | input | 1 | 1: rising edge of c8In is active; 0: falling |
| cfgOutPol | input | 1 | Level of c8Out and c16Out at frame position 0 |
| frameStart | output | 1 | One-cycle strobe at bit 0 of channel 0 |
| styleValid | output | 1 | Pulse convention has been settled |
| styleHigh | output | 1 | 1: active-high pulse; 0: active-low pulse |
| widthErr | output | 1 | Sticky flag for a pulse of the wrong width |
| fp8Out | output | 1 | Regenerated frame pulse timed to c8Out |
| fp16Out | output | 1 | Regenerated frame pulse timed to c16Out |
| c8Out | output | 1 | Output clock at the bit rate |
| c16Out | output | 1 | Output clock at twice the bit rate |

## Verification
The hardest state to reach from the ports is a switch to the active-high convention after reset. Before lock, runs are measured against the default active-low level. When the convention flips, the run counter must be cleared, or the flip itself would show up as a width error. Each stimulus vector applies a reset and then plays whole frames, with the frame-pulse edges placed a few cycles ahead of the bit boundary. This lets several frames pass so the vote settles and the generator resynchronises on a clean boundary. The bench then checks, in one later frame:

- that frameStart falls on exactly one predicted cycle;
- the output clock levels at frame position 0;
- both regenerated pulses on every cycle.

The vectors with the wrong pulse width check that the error stays set and no frameStart appears.

// File: rtl/fpsg_pkg.sv
package fpsg_pkg;
  // One sample of the frame-pulse line per active bit-clock edge
  typedef struct packed {
    logic tick;
    logic level;
  } sampleEv_t;

  // Strobes and state passed from the style control to the generator
  typedef struct packed {
    logic frameStart;
    logic styleValid;
    logic styleHigh;
  } genCtl_t;
endpackage

// File: rtl/fpEdgeSampler.sv
module fpEdgeSampler
  import fpsg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      c8In,
  input  logic      fpIn,
  input  logic      cfgRiseEdge,
  output sampleEv_t ev
);
  // one extra stage on the clock path gives the previous level for edge detection
  logic [SYNC_STAGES:0]   c8Pipe;
  logic [SYNC_STAGES-1:0] fpPipe;

  generate
    if (SYNC_STAGES == 1) begin : g_oneStage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          c8Pipe <= '0;
          fpPipe <= '0;
        end else begin
          c8Pipe <= {c8Pipe[0], c8In};
          fpPipe <= fpIn;
        end
      end
    end else begin : g_multiStage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          c8Pipe <= '0;
          fpPipe <= '0;
        end else begin
          c8Pipe <= {c8Pipe[SYNC_STAGES-1:0], c8In};
          fpPipe <= {fpPipe[SYNC_STAGES-2:0], fpIn};
        end
      end
    end
  endgenerate

  logic c8Cur, c8Prev;
  assign c8Cur  = c8Pipe[SYNC_STAGES-1];
  assign c8Prev = c8Pipe[SYNC_STAGES];

  always_comb begin
    ev.tick  = cfgRiseEdge ? (c8Cur & ~c8Prev) : (~c8Cur & c8Prev);
    ev.level = fpPipe[SYNC_STAGES-1];
  end
endmodule

// File: rtl/fpStyleCtrl.sv
module fpStyleCtrl
  import fpsg_pkg::*;
#(
  parameter int C8_PER_FRAME = 1024
) (
  input  logic      clk,
  input  logic      rstN,
  input  sampleEv_t ev,
  input  logic      cfgDoubleWidth,
  output genCtl_t   gc,
  output logic      widthErr
);
  localparam int WIN_W = $clog2(C8_PER_FRAME);
  localparam int CNT_W = WIN_W + 1;
  localparam logic [WIN_W-1:0] WIN_LAST  = WIN_W'(C8_PER_FRAME - 1);
  localparam logic [CNT_W-1:0] HALF_WIN  = CNT_W'(C8_PER_FRAME / 2);

  logic [WIN_W-1:0] winCnt;
  logic [CNT_W-1:0] highCnt;
  logic             prevVote, havePrev;
  logic             styleValid, styleHigh, frameStart;
  logic [1:0]       runLen;

  logic [CNT_W-1:0] highNext;
  logic             winEnd, voteLow, lockHit, newHigh, flip, isActive;
  logic [1:0]       wantLen;

  always_comb begin
    highNext = highCnt + CNT_W'(ev.level);
    winEnd   = (winCnt == WIN_LAST);
    voteLow  = (highNext > HALF_WIN);        // mostly high line: active-low pulse
    lockHit  = winEnd && havePrev && (voteLow == prevVote);
    newHigh  = ~voteLow;
    flip     = lockHit && (newHigh != styleHigh);
    isActive = (ev.level == styleHigh);
    wantLen  = cfgDoubleWidth ? 2'd2 : 2'd1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winCnt     <= '0;
      highCnt    <= '0;
      prevVote   <= 1'b0;
      havePrev   <= 1'b0;
      styleValid <= 1'b0;
      styleHigh  <= 1'b0;
      runLen     <= '0;
      frameStart <= 1'b0;
      widthErr   <= 1'b0;
    end else begin
      frameStart <= 1'b0;
      if (ev.tick) begin
        // frame-length voting window
        winCnt  <= winEnd ? '0 : winCnt + 1'b1;
        highCnt <= winEnd ? '0 : highNext;
        if (winEnd) begin
          prevVote <= voteLow;
          havePrev <= 1'b1;
        end
        if (lockHit) begin
          styleValid <= 1'b1;
          styleHigh  <= newHigh;
        end
        // pulse run measurement
        if (flip) begin
          runLen <= '0;
        end else if (isActive) begin
          runLen <= (runLen == 2'd3) ? 2'd3 : runLen + 1'b1;
        end else begin
          if (runLen != 2'd0 && styleValid) begin
            if (runLen == wantLen) frameStart <= 1'b1;
            else                   widthErr   <= 1'b1;
          end
          runLen <= '0;
        end
      end
    end
  end

  always_comb begin
    gc.frameStart = frameStart;
    gc.styleValid = styleValid;
    gc.styleHigh  = styleHigh;
  end
endmodule

// File: rtl/fpPulseGen.sv
module fpPulseGen
  import fpsg_pkg::*;
#(
  parameter int OVS          = 16,
  parameter int C8_PER_FRAME = 1024
) (
  input  logic    clk,
  input  logic    rstN,
  input  genCtl_t gc,
  input  logic    cfgDoubleWidth,
  input  logic    cfgOutPol,
  output logic    fp8Out,
  output logic    fp16Out,
  output logic    c8Out,
  output logic    c16Out
);
  localparam int FRAME   = OVS * C8_PER_FRAME;
  localparam int POS_W   = $clog2(FRAME);
  localparam int LOG_OVS = $clog2(OVS);
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(FRAME - 1);
  localparam logic [POS_W-1:0] TH8_S    = POS_W'(FRAME - OVS);
  localparam logic [POS_W-1:0] TH8_D    = POS_W'(FRAME - 2 * OVS);
  localparam logic [POS_W-1:0] TH16_S   = POS_W'(FRAME - OVS / 2);
  localparam logic [POS_W-1:0] TH16_D   = POS_W'(FRAME - OVS);

  logic [POS_W-1:0] pos;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              pos <= '0;
    else if (gc.frameStart) pos <= '0;
    else                    pos <= (pos == POS_LAST) ? '0 : pos + 1'b1;
  end

  logic [LOG_OVS-1:0] phase;
  logic               act8, act16;

  always_comb begin
    phase  = pos[LOG_OVS-1:0];
    c8Out  = cfgOutPol ^ phase[LOG_OVS-1];
    c16Out = cfgOutPol ^ phase[LOG_OVS-2];
    act8   = (pos >= (cfgDoubleWidth ? TH8_D  : TH8_S));
    act16  = (pos >= (cfgDoubleWidth ? TH16_D : TH16_S));
    if (gc.styleValid) begin
      fp8Out  = act8  ? gc.styleHigh : ~gc.styleHigh;
      fp16Out = act16 ? gc.styleHigh : ~gc.styleHigh;
    end else begin
      fp8Out  = 1'b1;
      fp16Out = 1'b1;
    end
  end
endmodule

// File: rtl/fpStyleGen.sv
module fpStyleGen
  import fpsg_pkg::*;
#(
  parameter int OVS          = 16,
  parameter int C8_PER_FRAME = 1024,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic c8In,
  input  logic fpIn,
  input  logic cfgDoubleWidth,
  input  logic cfgRiseEdge,
  input  logic cfgOutPol,
  output logic frameStart,
  output logic styleValid,
  output logic styleHigh,
  output logic widthErr,
  output logic fp8Out,
  output logic fp16Out,
  output logic c8Out,
  output logic c16Out
);
  sampleEv_t ev;
  genCtl_t   gc;

  fpEdgeSampler #(.SYNC_STAGES(SYNC_STAGES)) i_sampler (
    .clk(clk), .rstN(rstN), .c8In(c8In), .fpIn(fpIn),
    .cfgRiseEdge(cfgRiseEdge), .ev(ev)
  );

  fpStyleCtrl #(.C8_PER_FRAME(C8_PER_FRAME)) i_ctrl (
    .clk(clk), .rstN(rstN), .ev(ev), .cfgDoubleWidth(cfgDoubleWidth),
    .gc(gc), .widthErr(widthErr)
  );

  fpPulseGen #(.OVS(OVS), .C8_PER_FRAME(C8_PER_FRAME)) i_gen (
    .clk(clk), .rstN(rstN), .gc(gc), .cfgDoubleWidth(cfgDoubleWidth),
    .cfgOutPol(cfgOutPol), .fp8Out(fp8Out), .fp16Out(fp16Out),
    .c8Out(c8Out), .c16Out(c16Out)
  );

  assign frameStart = gc.frameStart;
  assign styleValid = gc.styleValid;
  assign styleHigh  = gc.styleHigh;
endmodule

// File: rtl/fpStyleGenChk.sv
module fpStyleGenChk (
  input logic clk,
  input logic rstN,
  input logic frameStart,
  input logic styleValid,
  input logic styleHigh,
  input logic widthErr,
  input logic fp8Out,
  input logic fp16Out,
  input logic c8Out,
  input logic c16Out,
  input logic cfgOutPol
);
  // R3
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> !frameStart);

  // R3
  strobe_after_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> styleValid);

  // R2
  lock_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    styleValid |=> styleValid);

  // R4
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    widthErr |=> widthErr);

  // R5
  boundary_clock_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> (c8Out == cfgOutPol) && (c16Out == cfgOutPol));

  // R6
  pulse_nesting_chk: assert property (@(posedge clk) disable iff (!rstN)
    (styleValid && fp16Out == styleHigh) |-> (fp8Out == styleHigh));

  // R7
  idle_before_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    !styleValid |-> (fp8Out && fp16Out));
endmodule

bind fpStyleGen fpStyleGenChk i_fpStyleGenChk (
  .clk(clk), .rstN(rstN), .frameStart(frameStart), .styleValid(styleValid),
  .styleHigh(styleHigh), .widthErr(widthErr), .fp8Out(fp8Out),
  .fp16Out(fp16Out), .c8Out(c8Out), .c16Out(c16Out), .cfgOutPol(cfgOutPol)
);

// File: tb/test_fpStyleGen.sv
`timescale 1ns/1ps
module test_fpStyleGen;
  localparam int OVS   = 16;
  localparam int BITS  = 32;
  localparam int FRAME = OVS * BITS;
  localparam int NVEC  = 6;
  // {double, rise, activeHigh, outPol, pulseTwo, expectErr}
  localparam logic [5:0] VEC [NVEC] = '{
    6'b000000, 6'b100110, 6'b011100, 6'b111010, 6'b000011, 6'b100101
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic c8In = 1'b0, fpIn = 1'b1;
  logic cfgDoubleWidth = 1'b0, cfgRiseEdge = 1'b0, cfgOutPol = 1'b0;
  logic frameStart, styleValid, styleHigh, widthErr;
  logic fp8Out, fp16Out, c8Out, c16Out;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  fpStyleGen #(.OVS(OVS), .C8_PER_FRAME(BITS)) i_fpStyleGen (
    .clk(clk), .rstN(rstN), .c8In(c8In), .fpIn(fpIn),
    .cfgDoubleWidth(cfgDoubleWidth), .cfgRiseEdge(cfgRiseEdge),
    .cfgOutPol(cfgOutPol), .frameStart(frameStart), .styleValid(styleValid),
    .styleHigh(styleHigh), .widthErr(widthErr), .fp8Out(fp8Out),
    .fp16Out(fp16Out), .c8Out(c8Out), .c16Out(c16Out)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // One frame of stimulus; observation at iteration c reflects edges up to c-1
  task automatic runFrame(input bit doCheck, input bit act, input int pw,
                          input int lat, input bit expErr, input int w);
    int fsCount = 0, fsAt = -1, bad8 = 0, bad16 = 0;
    for (int c = 0; c < FRAME; c++) begin
      @(negedge clk);
      if (doCheck) begin
        int pos;
        logic e8, e16;
        pos = ((c - lat - 1) % FRAME + FRAME) % FRAME;
        e8  = (pos >= FRAME - w * OVS)     ? act : ~act;
        e16 = (pos >= FRAME - w * OVS / 2) ? act : ~act;
        if (frameStart) begin
          fsCount++;
          fsAt = c;
        end
        if (!expErr) begin
          if (fp8Out !== e8)   bad8++;
          if (fp16Out !== e16) bad16++;
          if (c == lat + 1) begin
            check(c8Out === cfgOutPol, "R5", "c8Out at position 0", c8Out, cfgOutPol);
            check(c16Out === cfgOutPol, "R5", "c16Out at position 0", c16Out, cfgOutPol);
          end
          if (c == lat + 1 + OVS / 2)
            check(c8Out === ~cfgOutPol, "R5", "c8Out half period", c8Out, ~cfgOutPol);
          if (c == lat + 1 + OVS / 4)
            check(c16Out === ~cfgOutPol, "R5", "c16Out half period", c16Out, ~cfgOutPol);
        end
      end
      c8In = ((c % OVS) < OVS / 2);
      fpIn = ((((c + 4) / OVS) % BITS) >= BITS - pw) ? act : ~act;
    end
    if (doCheck) begin
      if (expErr) begin
        check(fsCount == 0, "R4", "frameStart on bad width", fsCount, 0);
      end else begin
        check(fsCount == 1, "R3", "frameStart count", fsCount, 1);
        check(fsAt == lat, "R1", "frameStart cycle for edge choice", fsAt, lat);
        check(bad8 == 0, "R6", "fp8Out mismatching cycles", bad8, 0);
        check(bad16 == 0, "R7", "fp16Out mismatching cycles", bad16, 0);
      end
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int v = 0; v < NVEC; v++) begin
      bit act, expErr;
      int pw, w, lat;
      cfgDoubleWidth = VEC[v][5];
      cfgRiseEdge    = VEC[v][4];
      act            = VEC[v][3];
      cfgOutPol      = VEC[v][2];
      pw             = VEC[v][1] ? 2 : 1;
      expErr         = VEC[v][0];
      w              = cfgDoubleWidth ? 2 : 1;
      lat            = cfgRiseEdge ? 3 : 11;
      rstN = 1'b0;
      c8In = 1'b0;
      fpIn = ~act;
      repeat (5) @(negedge clk);
      // R8 reset state
      check(frameStart === 1'b0 && styleValid === 1'b0 && widthErr === 1'b0,
            "R8", "status in reset", {frameStart, styleValid, widthErr}, 0);
      check(fp8Out === 1'b1 && fp16Out === 1'b1, "R8", "pulses idle in reset",
            {fp8Out, fp16Out}, 3);
      check(c8Out === cfgOutPol, "R8", "c8Out in reset", c8Out, cfgOutPol);
      rstN = 1'b1;
      runFrame(1'b0, act, pw, lat, expErr, w);
      // R7 pulses held high while still unlocked
      check(fp8Out === 1'b1, "R7", "fp8Out before lock", fp8Out, 1);
      for (int f = 1; f < 4; f++) runFrame(1'b0, act, pw, lat, expErr, w);
      check(styleValid === 1'b1, "R2", "convention settled", styleValid, 1);
      check(styleHigh === act, "R2", "detected convention", styleHigh, act);
      runFrame(1'b1, act, pw, lat, expErr, w);
      check(widthErr === expErr, "R4", "width error flag", widthErr, expErr);
    end
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule